// File: doc/BRIEF.md
# CPU Status Flag Register

This block is the eight-bit processor status word of a small CPU core. It keeps the ALU condition flags (carry, zero, negative, overflow, sign, half carry), one scratch bit used by the bit-copy instructions, and the global interrupt enable. Several sources can update it: the ALU writes flag results through a per-flag mask, interrupt logic clears and sets the enable, software clears or sets the enable directly, a bit-store operation loads the scratch bit, and software can replace the whole byte.

The sign flag is never stored on its own. It is always taken as the exclusive-or of the negative and overflow flags that are being written in that cycle. The global enable also gates the interrupt request that goes on to the core. The register does not save or restore its contents on interrupt entry or return. Only the enable bit reacts to those events.

Top module: `status_flags_reg`

## Requirements
- R1: The read port `rd_data` carries the byte with this layout: bit 7 I (global enable), bit 6 T (bit-copy storage), bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. The single-bit flag outputs match their bits in `rd_data`.
- R2: While reset is held and after it is released, all eight bits are 0.
- R3: When `sw_we` is high, the next byte equals `sw_wdata`, except that S becomes `sw_wdata[3] ^ sw_wdata[2]`.
- R4: After every update, S equals N XOR V, computed from the newly written N and V.
- R5: When `alu_we` is high, each of H, V, N, Z and C takes its bit of `alu_flags` only if the matching `alu_mask` bit is 1. The mapping is bit 4 H, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. Flags with a 0 mask bit keep their value.
- R6: `irq_take` clears I in the next cycle and leaves every other bit unchanged.
- R7: `irq_ret` sets I to 1 and leaves every other bit unchanged.
- R8: `gie_set` sets I and `gie_clr` clears I, and neither touches any other bit. If both are high in the same cycle, clear wins.
- R9: `gie_out` equals I. `irq_fwd` is `irq_pend` when I is 1, and 0 when I is 0.
- R10: `bst_en` copies `bst_bit` into T, and `flag_t` presents T for bit-load use.
- R11: The sources have this priority. A byte write overrides every other source in its cycle. `irq_take` overrides `gie_set`, `gie_clr` and `irq_ret`. ALU and bit-store updates combine with any change to the I bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 1 | ALU flag update strobe |
| alu_mask | input | 5 | Per-flag update mask {H,V,N,Z,C} |
| alu_flags | input | 5 | Flag results {H,V,N,Z,C} |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| irq_take | input | 1 | Interrupt accepted, clears enable |
| irq_ret | input | 1 | Return from interrupt, sets enable |
| bst_en | input | 1 | Bit-store strobe |
| bst_bit | input | 1 | Bit copied into T |
| sw_we | input | 1 | Software byte write strobe |
| sw_wdata | input | 8 | Software byte write data |
| irq_pend | input | 1 | Interrupt request from the prioritiser |
| rd_data | output | 8 | Full register read |
| flag_i | output | 1 | Global enable bit |
| flag_t | output | 1 | Bit-copy storage bit |
| flag_h | output | 1 | Half carry |
| flag_s | output | 1 | Sign |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| gie_out | output | 1 | Global interrupt enable |
| irq_fwd | output | 1 | Gated interrupt request |

## Verification
An ALU flag update can land in the same cycle as an interrupt acceptance or a return. A software byte write can collide with any of these sources. The bench drives these pairs in a single cycle. It checks that the flag bits follow the mask while I follows the enable priority, and that a byte write discards every other source. It also asserts `irq_take` and `gie_set` together, and `gie_set` and `gie_clr` together, to confirm that the clearing source wins.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int REG_W   = 8;
    localparam int ARITH_W = 5;

    // Mask/result bit positions inside the ALU vectors
    localparam int A_H = 4;
    localparam int A_V = 3;
    localparam int A_N = 2;
    localparam int A_Z = 1;
    localparam int A_C = 0;

    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

endpackage

// File: rtl/flag_arith_merge.sv
module flag_arith_merge
    import sreg_pkg::*;
(
    input  sreg_t              cur,
    input  logic               alu_we,
    input  logic [ARITH_W-1:0] alu_mask,
    input  logic [ARITH_W-1:0] alu_flags,
    input  logic               bst_en,
    input  logic               bst_bit,
    output sreg_t              nxt
);

    logic [ARITH_W-1:0] cur_ar;
    logic [ARITH_W-1:0] new_ar;

    assign cur_ar = {cur.h, cur.v, cur.n, cur.z, cur.c};

    // One merge mux per maskable flag
    for (genvar k = 0; k < ARITH_W; k++) begin : g_mrg
        assign new_ar[k] = (alu_we && alu_mask[k]) ? alu_flags[k] : cur_ar[k];
    end

    always_comb begin
        nxt   = cur;
        nxt.h = new_ar[A_H];
        nxt.v = new_ar[A_V];
        nxt.n = new_ar[A_N];
        nxt.z = new_ar[A_Z];
        nxt.c = new_ar[A_C];
        nxt.t = bst_en ? bst_bit : cur.t;
        nxt.s = new_ar[A_N] ^ new_ar[A_V];
    end

endmodule

// File: rtl/gie_next.sv
module gie_next (
    input  logic cur_i,
    input  logic irq_take,
    input  logic gie_clr,
    input  logic gie_set,
    input  logic irq_ret,
    output logic nxt_i
);

    always_comb begin
        if (irq_take)
            nxt_i = 1'b0;
        else if (gie_clr)
            nxt_i = 1'b0;
        else if (gie_set || irq_ret)
            nxt_i = 1'b1;
        else
            nxt_i = cur_i;
    end

endmodule

// File: rtl/status_flags_reg.sv
module status_flags_reg
    import sreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alu_we,
    input  logic [ARITH_W-1:0] alu_mask,
    input  logic [ARITH_W-1:0] alu_flags,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               irq_take,
    input  logic               irq_ret,
    input  logic               bst_en,
    input  logic               bst_bit,
    input  logic               sw_we,
    input  logic [REG_W-1:0]   sw_wdata,
    input  logic               irq_pend,
    output logic [REG_W-1:0]   rd_data,
    output logic               flag_i,
    output logic               flag_t,
    output logic               flag_h,
    output logic               flag_s,
    output logic               flag_v,
    output logic               flag_n,
    output logic               flag_z,
    output logic               flag_c,
    output logic               gie_out,
    output logic               irq_fwd
);

    sreg_t state_d, state_q;
    sreg_t merged;
    sreg_t sw_word;
    logic  i_nxt;

    flag_arith_merge u_merge (
        .cur       (state_q),
        .alu_we    (alu_we),
        .alu_mask  (alu_mask),
        .alu_flags (alu_flags),
        .bst_en    (bst_en),
        .bst_bit   (bst_bit),
        .nxt       (merged)
    );

    gie_next u_gie (
        .cur_i    (state_q.i),
        .irq_take (irq_take),
        .gie_clr  (gie_clr),
        .gie_set  (gie_set),
        .irq_ret  (irq_ret),
        .nxt_i    (i_nxt)
    );

    always_comb begin
        sw_word   = sreg_t'(sw_wdata);
        sw_word.s = sw_word.n ^ sw_word.v;
        state_d   = merged;
        state_d.i = i_nxt;
        if (sw_we)
            state_d = sw_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rd_data = state_q;
    assign flag_i  = state_q.i;
    assign flag_t  = state_q.t;
    assign flag_h  = state_q.h;
    assign flag_s  = state_q.s;
    assign flag_v  = state_q.v;
    assign flag_n  = state_q.n;
    assign flag_z  = state_q.z;
    assign flag_c  = state_q.c;
    assign gie_out = state_q.i;
    assign irq_fwd = irq_pend & state_q.i;

    AST_SIGN_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] == (rd_data[3] ^ rd_data[2]));  // R4

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !sw_we) |=> !gie_out);  // R6

    AST_RET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_take && !gie_clr && !sw_we) |=> gie_out);  // R7

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (rd_data[7:5] == $past(sw_wdata[7:5])) && (rd_data[3:0] == $past(sw_wdata[3:0])));  // R3

    AST_NO_FWD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_out |-> !irq_fwd);  // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !alu_we) |=> ({rd_data[5], rd_data[3:0]} == $past({rd_data[5], rd_data[3:0]})));  // R5

endmodule

// File: tb/sim_status_flags_reg.sv
module sim_status_flags_reg;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alu_we, gie_set, gie_clr, irq_take, irq_ret, bst_en, bst_bit, sw_we, irq_pend;
    logic [4:0] alu_mask, alu_flags;
    logic [7:0] sw_wdata;
    logic [7:0] rd_data;
    logic       flag_i, flag_t, flag_h, flag_s, flag_v, flag_n, flag_z, flag_c, gie_out, irq_fwd;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    logic [7:0] model;
    logic [8:0] q_exp[$];
    string      q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    status_flags_reg u0 (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_mask(alu_mask), .alu_flags(alu_flags),
        .gie_set(gie_set), .gie_clr(gie_clr), .irq_take(irq_take), .irq_ret(irq_ret),
        .bst_en(bst_en), .bst_bit(bst_bit), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .irq_pend(irq_pend), .rd_data(rd_data), .flag_i(flag_i), .flag_t(flag_t),
        .flag_h(flag_h), .flag_s(flag_s), .flag_v(flag_v), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .gie_out(gie_out), .irq_fwd(irq_fwd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_we = 0; alu_mask = '0; alu_flags = '0; gie_set = 0; gie_clr = 0;
        irq_take = 0; irq_ret = 0; bst_en = 0; bst_bit = 0; sw_we = 0; sw_wdata = '0;
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input string req,
                        input logic w, input logic [7:0] wd,
                        input logic tk, input logic rt, input logic st, input logic cl,
                        input logic aw, input logic [4:0] am, input logic [4:0] af,
                        input logic be, input logic bb, input logic pd);
        logic [7:0] nx;
        @(negedge clk);
        sw_we = w; sw_wdata = wd; irq_take = tk; irq_ret = rt; gie_set = st; gie_clr = cl;
        alu_we = aw; alu_mask = am; alu_flags = af; bst_en = be; bst_bit = bb; irq_pend = pd;
        nx = model;
        if (w) begin
            nx    = wd;
            nx[4] = wd[3] ^ wd[2];
        end else begin
            if (tk)           nx[7] = 1'b0;
            else if (cl)      nx[7] = 1'b0;
            else if (st || rt) nx[7] = 1'b1;
            if (aw) begin
                if (am[4]) nx[5] = af[4];
                if (am[3]) nx[3] = af[3];
                if (am[2]) nx[2] = af[2];
                if (am[1]) nx[1] = af[1];
                if (am[0]) nx[0] = af[0];
            end
            if (be) nx[6] = bb;
            nx[4] = nx[3] ^ nx[2];
        end
        model = nx;
        q_exp.push_back({nx, pd & nx[7]});
        q_req.push_back(req);
    endtask

    // Monitor: compares one cycle after each driven step, away from the edge
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [8:0] e;
            string      r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            check({r, " rd_data"}, 32'(rd_data), 32'(e[8:1]));
            check({r, " R9 irq_fwd"}, 32'(irq_fwd), 32'(e[0]));
            check({r, " R1 flags"}, 32'({flag_i, flag_t, flag_h, flag_s, flag_v, flag_n, flag_z, flag_c, gie_out}),
                  32'({e[8:1], e[8]}));
        end
    end

    initial begin
        idle();
        irq_pend = 0;
        rst_n = 0;
        model = '0;
        repeat (3) @(negedge clk);
        check("R2 reset", 32'(rd_data), 32'h00);
        rst_n = 1;
        @(negedge clk);
        check("R2 after release", 32'(rd_data), 32'h00);

        // R3 byte write, S forced from N^V (wd S bit deliberately wrong)
        step("R3 write", 1, 8'b1110_0101, 0,0,0,0, 0,5'h00,5'h00, 0,0, 1);
        step("R3 write2", 1, 8'b0001_1000, 0,0,0,0, 0,5'h00,5'h00, 0,0, 1);
        // R5 masked ALU update: only C and N
        step("R5 mask", 0, 8'h00, 0,0,0,0, 1,5'b00101,5'b11111, 0,0, 0);
        // R4 sign from new N and V
        step("R4 sign", 0, 8'h00, 0,0,0,0, 1,5'b11111,5'b01010, 0,0, 0);
        step("R5 zero mask", 0, 8'h00, 0,0,0,0, 1,5'b00000,5'b10101, 0,0, 0);
        // R8 set then clear, and both together
        step("R8 set", 0, 8'h00, 0,0,1,0, 0,5'h00,5'h00, 0,0, 1);
        step("R8 both clear wins", 0, 8'h00, 0,0,1,1, 0,5'h00,5'h00, 0,0, 1);
        step("R7 ret", 0, 8'h00, 0,1,0,0, 0,5'h00,5'h00, 0,0, 1);
        // R6 take with concurrent ALU update
        step("R6 take+alu", 0, 8'h00, 1,0,0,0, 1,5'b11111,5'b10100, 0,0, 1);
        // R11 take beats set
        step("R11 take vs set", 0, 8'h00, 1,0,1,0, 0,5'h00,5'h00, 0,0, 1);
        // R7 ret with ALU update in same cycle
        step("R7 ret+alu", 0, 8'h00, 0,1,0,0, 1,5'b01000,5'b01000, 0,0, 1);
        // R10 bit store
        step("R10 bst1", 0, 8'h00, 0,0,0,0, 0,5'h00,5'h00, 1,1, 0);
        step("R10 bst0", 0, 8'h00, 0,0,0,0, 0,5'h00,5'h00, 1,0, 1);
        step("R10 bst1 again", 0, 8'h00, 0,0,0,0, 1,5'b00010,5'b00010, 1,1, 1);
        // R11 byte write overrides everything
        step("R11 write wins", 1, 8'b0000_0110, 0,0,1,0, 1,5'b11111,5'b11111, 1,1, 1);
        step("R11 write vs take", 1, 8'b1000_1000, 1,0,0,0, 0,5'h00,5'h00, 0,0, 1);
        // R9 gating with I low
        step("R9 gate off", 0, 8'h00, 0,0,0,1, 0,5'h00,5'h00, 0,0, 1);
        step("R9 gate on", 0, 8'h00, 0,0,1,0, 0,5'h00,5'h00, 0,0, 1);

        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

endmodule